// File: doc/BRIEF.md
# Configurable UART Transmit Framer

This block turns parallel characters into an asynchronous serial stream on a single transmit line. An 8-bit line configuration input chooses the frame shape: how many data bits are sent, how long the stop period lasts, whether a parity bit is added and how it is computed, whether that parity bit is forced from a ninth data bit, and whether the line is held in the break (low) state. Characters arrive through a valid/ready handshake from an upstream FIFO, and bit timing comes from a one-cycle baud tick generated elsewhere, with 16 ticks per bit.

The line configuration is captured together with each character, so the settings used for a frame are fixed once that frame begins. Software may rewrite the configuration at any time, and a new setting applies only from the next frame. A break request that arrives during a frame waits for that frame's stop period to end. The line then stays low until the request is withdrawn, and after that it returns to idle high.

Top module: `uart_tx_framer`

## Requirements
- R1: After reset the line is idle high, busy is low and in_ready is high.
- R2: A frame is one low start bit, then the data bits LSB first, with the count set by line_cfg[1:0] (00 = 5, 01 = 6, 10 = 7, 11 = 8). Every start, data and parity bit lasts exactly 16 baud ticks.
- R3: The stop period is high. It lasts 16 ticks when line_cfg[2] = 0. When line_cfg[2] = 1 it lasts 24 ticks for 5-bit words and 32 ticks for every other word length.
- R4: When line_cfg[3] = 1, one parity bit follows the last data bit. With line_cfg[4] = 1 the parity is even (the data bits and the parity bit together hold an even number of ones). With line_cfg[4] = 0 the parity is odd.
- R5: When line_cfg[3] = 1 and line_cfg[5] = 1, the parity bit equals in_ninth. When line_cfg[3] = 0, line_cfg[5] has no effect and no parity bit is sent.
- R6: A character is accepted on a rising edge at which in_valid and in_ready are both high. in_ready is high only while the block is idle and no break is requested. busy rises on the edge of acceptance and falls on the edge after the last stop tick.
- R7: The configuration is sampled on the edge of acceptance. Changes to line_cfg during a frame do not alter that frame.
- R8: When line_cfg[6] = 1 while the block is idle, the line goes low and busy goes high on the next edge, and in_ready stays low. They stay that way for as long as the bit is set. When the bit clears, the line returns high and busy returns low on the next edge.
- R9: A break requested during a frame takes effect only after that frame's stop period has completed.
- R10: line_cfg[7] has no effect on the frame.
- R11: Data bits above the selected word length are neither sent nor included in the parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle baud tick, 16 per bit |
| line_cfg | input | 8 | Frame configuration (length, stop, parity, forced parity, break) |
| in_data | input | 8 | Character to send |
| in_ninth | input | 1 | Forced parity value that travels with the character |
| in_valid | input | 1 | Character available |
| in_ready | output | 1 | Block can accept a character |
| txd | output | 1 | Serial transmit line |
| busy | output | 1 | Frame or break in progress |

## Verification
The state of this block shows at the ports almost at once. A wrong bit index or a wrong shift shows up in the txd samples of the very next bit period. A wrong tick count changes the measured length of a bit or of the stop period in the same frame. A configuration that is not properly latched shows up as a frame reshaped by a mid-frame write. A wrong break sequence shows up within one cycle as a high line or a raised in_ready while busy is high. The scoreboard records txd on every tick while busy is high and compares both the total tick count and every sample against the frame built from the requirements.

// File: rtl/uart_tx_framer.sv
module uart_tx_framer #(
  parameter int OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [7:0] line_cfg,
  input  logic [7:0] in_data,
  input  logic       in_ninth,
  input  logic       in_valid,
  output logic       in_ready,
  output logic       txd,
  output logic       busy
);
  localparam int CW = $clog2(2 * OVERSAMPLE);
  localparam logic [CW-1:0] BIT_LAST  = CW'(OVERSAMPLE - 1);
  localparam logic [CW-1:0] STOP_MID  = CW'(OVERSAMPLE + OVERSAMPLE / 2 - 1);
  localparam logic [CW-1:0] STOP_LONG = CW'(2 * OVERSAMPLE - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_BRK} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [CW-1:0] stop_last;
  logic [2:0]    bidx;
  logic [2:0]    nlast;
  logic [7:0]    shf;
  logic          par_q;
  logic          par_en;

  logic [7:0]    dmask;
  logic [7:0]    mdata;
  logic          par_calc;
  logic          last_hit;
  logic          framing;

  assign dmask    = 8'hff >> (3'd3 - {1'b0, line_cfg[1:0]});
  assign mdata    = in_data & dmask;
  assign par_calc = line_cfg[5] ? in_ninth : (line_cfg[4] ? ^mdata : ~^mdata);
  assign framing  = (st == S_START) || (st == S_DATA) || (st == S_PAR) || (st == S_STOP);
  assign last_hit = (st == S_STOP) ? (cnt == stop_last) : (cnt == BIT_LAST);

  assign in_ready = (st == S_IDLE) && !line_cfg[6];
  assign busy     = (st != S_IDLE);

  always_comb begin
    case (st)
      S_START, S_BRK: txd = 1'b0;
      S_DATA:         txd = shf[0];
      S_PAR:          txd = par_q;
      default:        txd = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!framing) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= last_hit ? '0 : cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      bidx      <= '0;
      shf       <= '0;
      par_q     <= 1'b0;
      nlast     <= 3'd7;
      par_en    <= 1'b0;
      stop_last <= BIT_LAST;
    end else begin
      case (st)
        S_IDLE: begin
          if (line_cfg[6]) begin
            st <= S_BRK;
          end else if (in_valid) begin
            st        <= S_START;
            shf       <= in_data;
            nlast     <= 3'd4 + {1'b0, line_cfg[1:0]};
            par_en    <= line_cfg[3];
            par_q     <= par_calc;
            stop_last <= !line_cfg[2] ? BIT_LAST :
                         (line_cfg[1:0] == 2'b00 ? STOP_MID : STOP_LONG);
          end
        end
        S_BRK: if (!line_cfg[6]) st <= S_IDLE;
        S_START: if (tick && last_hit) begin
          st   <= S_DATA;
          bidx <= '0;
        end
        S_DATA: if (tick && last_hit) begin
          shf <= shf >> 1;
          if (bidx == nlast) st <= par_en ? S_PAR : S_STOP;
          else               bidx <= bidx + 1'b1;
        end
        S_PAR:  if (tick && last_hit) st <= S_STOP;
        S_STOP: if (tick && last_hit) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module uart_tx_framer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] line_cfg,
  input logic       in_valid,
  input logic       in_ready,
  input logic       txd,
  input logic       busy
);
  // R1
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);
  // R6
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !busy);
  // R6
  start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (busy && !txd));
  // R8
  brk_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && line_cfg[6]) |=> (busy && !txd && !in_ready));
endmodule

bind uart_tx_framer uart_tx_framer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .line_cfg(line_cfg), .in_valid(in_valid),
  .in_ready(in_ready), .txd(txd), .busy(busy)
);

// File: tb/tb_uart_tx_framer.sv
`timescale 1ns/1ps
module tb_uart_tx_framer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick;
  logic [7:0] line_cfg = 8'h03;
  logic [7:0] in_data = '0;
  logic       in_ninth = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready, txd, busy;

  int tests = 0;
  int failed = 0;
  bit done = 0;
  int tc = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) tc <= (tc == 2) ? 0 : tc + 1;
  assign tick = (tc == 2);

  uart_tx_framer dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .line_cfg(line_cfg),
    .in_data(in_data), .in_ninth(in_ninth), .in_valid(in_valid),
    .in_ready(in_ready), .txd(txd), .busy(busy)
  );

  typedef struct {
    bit          brk;
    logic [11:0] bits;
    int          nbits;
    int          stop;
    string       tag;
  } exp_t;

  exp_t q[$];

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      failed++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic exp_t mk(input logic [7:0] d, input logic nin,
                              input logic [7:0] c, input string tag);
    exp_t e;
    int n;
    logic [7:0] md;
    n = 5 + int'(c[1:0]);
    md = d & (8'hff >> (8 - n));
    e.brk = 0;
    e.tag = tag;
    e.bits = '0;
    for (int i = 0; i < n; i++) e.bits[1 + i] = d[i];
    e.nbits = 1 + n;
    if (c[3]) begin
      e.bits[e.nbits] = c[5] ? nin : (c[4] ? ^md : ~^md);
      e.nbits++;
    end
    e.stop = !c[2] ? 16 : (n == 5 ? 24 : 32);
    return e;
  endfunction

  // Monitor: records txd at each tick while busy, compares when busy falls
  logic rec [0:2047];
  int   nrec = 0;
  bit   pbusy = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy && tick && nrec < 2048) begin
        rec[nrec] = txd;
        nrec++;
      end
      if (pbusy && !busy) begin
        if (q.size() == 0) begin
          chk(0, "R6", "unexpected frame end, queue depth", 0, 1);
        end else begin
          exp_t e;
          int bad, first, act, expv;
          e = q.pop_front();
          bad = 0; first = -1; act = 0; expv = 0;
          if (e.brk) begin
            chk(nrec > 0, e.tag, "break tick count", nrec, 1);
            for (int i = 0; i < nrec; i++)
              if (rec[i] !== 1'b0) begin
                bad++;
                if (first < 0) begin first = i; act = 1; expv = 0; end
              end
            chk(bad == 0, e.tag, "break line level", act, expv);
          end else begin
            chk(nrec == 16 * e.nbits + e.stop, e.tag, "frame tick count",
                nrec, 16 * e.nbits + e.stop);
            for (int i = 0; i < nrec; i++) begin
              logic ev;
              ev = (i < 16 * e.nbits) ? e.bits[i / 16] : 1'b1;
              if (rec[i] !== ev) begin
                bad++;
                if (first < 0) begin first = i; act = int'(rec[i]); expv = int'(ev); end
              end
            end
            chk(bad == 0, e.tag, "frame line samples", act, expv);
          end
        end
        nrec = 0;
      end
      pbusy = busy;
    end
  end

  task automatic send(input logic [7:0] d, input logic nin,
                      input logic [7:0] c, input string tag);
    @(negedge clk);
    line_cfg = c;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    q.push_back(mk(d, nin, c, tag));
    in_data = d;
    in_ninth = nin;
    in_valid = 1'b1;
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic drain();
    int guard;
    guard = 0;
    while ((q.size() != 0 || busy) && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(txd == 1'b1, "R1", "txd after reset", int'(txd), 1);
    chk(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);

    send(8'hA5, 0, 8'h03, "R2");
    @(negedge clk);
    chk(in_ready == 1'b0 && busy == 1'b1, "R6", "ready/busy during frame",
        int'({in_ready, busy}), 1);
    send(8'h2A, 0, 8'h01, "R2");
    send(8'h5B, 0, 8'h02, "R2");
    send(8'hF3, 0, 8'h00, "R11");
    send(8'h16, 0, 8'h04, "R3");
    send(8'hC3, 0, 8'h07, "R3");
    send(8'h5D, 0, 8'h06, "R3");
    send(8'h35, 0, 8'h1A, "R4");
    send(8'h81, 0, 8'h0B, "R4");
    send(8'hE7, 0, 8'h1D, "R11");
    send(8'h40, 1, 8'h2B, "R5");
    send(8'hFF, 0, 8'h3B, "R5");
    send(8'h99, 1, 8'h23, "R5");
    send(8'h3C, 0, 8'h83, "R10");
    drain();

    // R7: change configuration mid-frame
    send(8'h6E, 0, 8'h03, "R7");
    repeat (100) @(negedge clk);
    line_cfg = 8'h1C;
    drain();

    // R9: break requested mid-frame waits for frame end
    send(8'h0F, 0, 8'h03, "R9");
    repeat (100) @(negedge clk);
    line_cfg = 8'h43;
    q.push_back('{brk: 1, bits: '0, nbits: 0, stop: 0, tag: "R9"});
    repeat (1500) @(negedge clk);
    chk(txd == 1'b0 && in_ready == 1'b0, "R9", "break after frame",
        int'({txd, in_ready}), 0);
    line_cfg = 8'h03;
    drain();

    // R8: break while idle, in_valid is ignored
    @(negedge clk);
    q.push_back('{brk: 1, bits: '0, nbits: 0, stop: 0, tag: "R8"});
    line_cfg = 8'h43;
    in_data = 8'h55;
    in_valid = 1'b1;
    repeat (150) @(negedge clk);
    chk(in_ready == 1'b0, "R8", "in_ready during break", int'(in_ready), 0);
    chk(busy == 1'b1 && txd == 1'b0, "R8", "busy/txd during break",
        int'({busy, txd}), 2);
    in_valid = 1'b0;
    @(negedge clk);
    line_cfg = 8'h03;
    @(negedge clk);
    chk(busy == 1'b0 && txd == 1'b1, "R8", "release after break",
        int'({busy, txd}), 1);
    drain();
    chk(q.size() == 0, "R6", "pending expected frames", q.size(), 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      failed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, failed);
      $finish;
    end
  end
endmodule